// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Peripheral Overrides

This block is one general-purpose I/O port of eight pins. Software reaches three registers through a small register bus. The direction register picks which pins drive the pad. The output register sets the driven level, and on an input pin it also requests the weak pull-up. The pin-state register is read-only and returns the pad levels after synchronization to the clock.

Any on-chip peripheral can take control of a single pin. It does so through four enable/value pairs for that pin, one each for the pull-up, the driver enable, the driven level and the digital input enable. When an enable is high, its value is used in place of the control that comes from the registers. Two signals are shared by every pin: a sleep input that shuts off the digital input path, and a global pull-up disable. Each pin also gives peripherals its synchronized input level.

Top module: `gpio_port`

## Requirements
- R1: While rst_ni is low, and after it is released with no write made, the direction and output registers read 0. With no override active, pad_oe_o, pad_out_o and pad_pu_o are all 0.
- R2: A write (wr_en_i=1) at rising clock edge k loads the register chosen by addr_i. Address 1 selects direction and address 2 selects output. The new value is visible after edge k. Writes to address 0 (pin state) and address 3 change nothing.
- R3: pad_oe_o[n] equals dir_ovr_val_i[n] when dir_ovr_en_i[n]=1. Otherwise it equals direction bit n.
- R4: pad_out_o[n] equals out_ovr_val_i[n] when out_ovr_en_i[n]=1. Otherwise it equals output bit n.
- R5: With pu_ovr_en_i[n]=0, pad_pu_o[n] is 1 only when direction bit n is 0, output bit n is 1 and pud_i is 0. These are the register bits, not the overridden values.
- R6: With pu_ovr_en_i[n]=1, pad_pu_o[n] equals pu_ovr_val_i[n] whatever the values of pud_i and the registers.
- R7: pad_ie_o[n] equals ie_ovr_val_i[n] when ie_ovr_en_i[n]=1. Otherwise it equals the inverse of sleep_i.
- R8: The synchronizer samples pad_in_i[n] AND pad_ie_o[n] on the falling clock edge. It passes the sample to periph_in_o[n] on the following rising edge. periph_in_o is 0 from reset until that first transfer.
- R9: rdata_o is combinational. It is 0 when rd_en_i=0. With rd_en_i=1, address 0 returns periph_in_o, address 1 returns direction, address 2 returns output and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep: gates digital inputs off |
| pud_i | input | 1 | Global pull-up disable |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select: 0 pin, 1 direction, 2 output |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pu_ovr_en_i | input | 8 | Pull-up override enables |
| pu_ovr_val_i | input | 8 | Pull-up override values |
| dir_ovr_en_i | input | 8 | Driver-enable override enables |
| dir_ovr_val_i | input | 8 | Driver-enable override values |
| out_ovr_en_i | input | 8 | Output-level override enables |
| out_ovr_val_i | input | 8 | Output-level override values |
| ie_ovr_en_i | input | 8 | Input-enable override enables |
| ie_ovr_val_i | input | 8 | Input-enable override values |
| pad_in_i | input | 8 | Pad levels |
| pad_out_o | output | 8 | Level to drive |
| pad_oe_o | output | 8 | Driver enables |
| pad_pu_o | output | 8 | Pull-up enables |
| pad_ie_o | output | 8 | Digital input enables |
| periph_in_o | output | 8 | Synchronized pad levels for peripherals |

## Verification
The hardest case to reach is an input enable that changes inside a clock period. If it changes between the falling-edge sample and the rising-edge transfer, the synchronizer holds a value that no longer matches the present gating. The bench therefore changes sleep_i, the input-enable overrides and the pads once per cycle, just after the rising edge, so every change lands ahead of a falling-edge sample. A reference model keyed to both clock edges tracks what each stage should hold. Override enables are drawn sparse so that override and register paths mix inside one vector, and directed phases sweep pud_i against a pull-up pattern written through the registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ADDR_PIN = 2'd0,
    ADDR_DIR = 2'd1,
    ADDR_OUT = 2'd2,
    ADDR_RSV = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] out_o,
  output logic [NPINS-1:0] rdata_o
);
  gpio_addr_e sel;
  assign sel = gpio_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      out_o <= '0;
    end else if (wr_en_i) begin
      if (sel == ADDR_DIR) dir_o <= wdata_i;
      if (sel == ADDR_OUT) out_o <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (sel)
        ADDR_PIN: rdata_o = pin_i;
        ADDR_DIR: rdata_o = dir_o;
        ADDR_OUT: rdata_o = out_o;
        default:  rdata_o = '0;
      endcase
    end
  end

  // R2
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> dir_o == $past(wdata_i));
  // R2
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd2) |=> $stable(out_o));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] d_i,
  output logic [NPINS-1:0] q_o
);
  logic [NPINS-1:0] s1_q;

  // first stage on the falling edge, half a cycle of settling
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else         s1_q <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= s1_q;
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl (
  input  logic sleep_i,
  input  logic pud_i,
  input  logic dir_i,
  input  logic out_i,
  input  logic pu_ovr_en_i,
  input  logic pu_ovr_val_i,
  input  logic dir_ovr_en_i,
  input  logic dir_ovr_val_i,
  input  logic out_ovr_en_i,
  input  logic out_ovr_val_i,
  input  logic ie_ovr_en_i,
  input  logic ie_ovr_val_i,
  input  logic pad_in_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic pad_pu_o,
  output logic pad_ie_o,
  output logic sync_d_o
);
  logic pu_reg;

  // pull-up request uses the register bits, not the overridden ones
  assign pu_reg    = ~dir_i & out_i & ~pud_i;
  assign pad_pu_o  = pu_ovr_en_i  ? pu_ovr_val_i  : pu_reg;
  assign pad_oe_o  = dir_ovr_en_i ? dir_ovr_val_i : dir_i;
  assign pad_out_o = out_ovr_en_i ? out_ovr_val_i : out_i;
  assign pad_ie_o  = ie_ovr_en_i  ? ie_ovr_val_i  : ~sleep_i;
  assign sync_d_o  = pad_in_i & pad_ie_o;

  always_comb begin
    // R5
    pu_pud_chk: assert (pu_ovr_en_i || !pad_pu_o || (!pud_i && !dir_i));
    // R7
    ie_sleep_chk: assert (ie_ovr_en_i || !(sleep_i && pad_ie_o));
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             pud_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] rdata_o,
  input  logic [NPINS-1:0] pu_ovr_en_i,
  input  logic [NPINS-1:0] pu_ovr_val_i,
  input  logic [NPINS-1:0] dir_ovr_en_i,
  input  logic [NPINS-1:0] dir_ovr_val_i,
  input  logic [NPINS-1:0] out_ovr_en_i,
  input  logic [NPINS-1:0] out_ovr_val_i,
  input  logic [NPINS-1:0] ie_ovr_en_i,
  input  logic [NPINS-1:0] ie_ovr_val_i,
  input  logic [NPINS-1:0] pad_in_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] pad_pu_o,
  output logic [NPINS-1:0] pad_ie_o,
  output logic [NPINS-1:0] periph_in_o
);
  logic [NPINS-1:0] dir_q, out_q, sync_d;

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .pin_i(periph_in_o), .dir_o(dir_q), .out_o(out_q), .rdata_o
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    gpio_pin_ctrl u_pin (
      .sleep_i, .pud_i,
      .dir_i(dir_q[n]),                 .out_i(out_q[n]),
      .pu_ovr_en_i(pu_ovr_en_i[n]),     .pu_ovr_val_i(pu_ovr_val_i[n]),
      .dir_ovr_en_i(dir_ovr_en_i[n]),   .dir_ovr_val_i(dir_ovr_val_i[n]),
      .out_ovr_en_i(out_ovr_en_i[n]),   .out_ovr_val_i(out_ovr_val_i[n]),
      .ie_ovr_en_i(ie_ovr_en_i[n]),     .ie_ovr_val_i(ie_ovr_val_i[n]),
      .pad_in_i(pad_in_i[n]),
      .pad_out_o(pad_out_o[n]), .pad_oe_o(pad_oe_o[n]),
      .pad_pu_o(pad_pu_o[n]),   .pad_ie_o(pad_ie_o[n]),
      .sync_d_o(sync_d[n])
    );

    // R3
    oe_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_ovr_en_i[n] |-> pad_oe_o[n] == dir_ovr_val_i[n]);
    // R6
    pu_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pu_ovr_en_i[n] |-> pad_pu_o[n] == pu_ovr_val_i[n]);
  end

  gpio_sync #(.NPINS(NPINS)) u_sync (
    .clk_i, .rst_ni, .d_i(sync_d), .q_o(periph_in_o)
  );

  // R9
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int N = 8;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sleep_i = 0, pud_i = 0, wr_en_i = 0, rd_en_i = 0;
  logic [1:0] addr_i = 0;
  logic [N-1:0] wdata_i = 0, pad_in_i = 0;
  logic [N-1:0] pu_en = 0, pu_val = 0, dir_en = 0, dir_val = 0;
  logic [N-1:0] out_en = 0, out_val = 0, ie_en = 0, ie_val = 0;
  logic [N-1:0] rdata_o, pad_out_o, pad_oe_o, pad_pu_o, pad_ie_o, periph_in_o;

  int vectors = 0, errors = 0;
  logic [N-1:0] m_dir = 0, m_out = 0, m_s1 = 0, m_s2 = 0;

  always #2 clk = ~clk;

  gpio_port #(.NPINS(N)) dut (
    .clk_i(clk), .rst_ni, .sleep_i, .pud_i, .wr_en_i, .rd_en_i, .addr_i,
    .wdata_i, .rdata_o,
    .pu_ovr_en_i(pu_en), .pu_ovr_val_i(pu_val),
    .dir_ovr_en_i(dir_en), .dir_ovr_val_i(dir_val),
    .out_ovr_en_i(out_en), .out_ovr_val_i(out_val),
    .ie_ovr_en_i(ie_en), .ie_ovr_val_i(ie_val),
    .pad_in_i, .pad_out_o, .pad_oe_o, .pad_pu_o, .pad_ie_o, .periph_in_o
  );

  function automatic logic [N-1:0] ie_ref();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = ie_en[i] ? ie_val[i] : !sleep_i;
    return r;
  endfunction

  // reference model: registers and output stage on rise, sampler on fall
  always @(posedge clk) begin
    if (!rst_ni) begin m_dir = 0; m_out = 0; m_s2 = 0; end
    else begin
      if (wr_en_i && addr_i == 2'd1) m_dir = wdata_i;
      if (wr_en_i && addr_i == 2'd2) m_out = wdata_i;
      m_s2 = m_s1;
    end
  end
  always @(negedge clk) begin
    if (!rst_ni) m_s1 = 0;
    else         m_s1 = pad_in_i & ie_ref();
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [N-1:0] e_oe, e_out, e_pu, e_rd;
    for (int i = 0; i < N; i++) begin
      e_oe[i]  = dir_en[i] ? dir_val[i] : m_dir[i];
      e_out[i] = out_en[i] ? out_val[i] : m_out[i];
      e_pu[i]  = pu_en[i] ? pu_val[i] : (!m_dir[i] && m_out[i] && !pud_i);
    end
    if (!rd_en_i) e_rd = 0;
    else case (addr_i)
      2'd0: e_rd = m_s2;
      2'd1: e_rd = m_dir;
      2'd2: e_rd = m_out;
      default: e_rd = 0;
    endcase
    chk("R3 pad_oe", pad_oe_o, e_oe);
    chk("R4 pad_out", pad_out_o, e_out);
    chk("R5/R6 pad_pu", pad_pu_o, e_pu);
    chk("R7 pad_ie", pad_ie_o, ie_ref());
    chk("R8 periph_in", periph_in_o, m_s2);
    chk("R2/R9 rdata", rdata_o, e_rd);
  endtask

  // inputs change 1 ns after the rising edge, checks 3 ns after it
  task automatic step();
    #2 compare();
    @(posedge clk); #1;
  endtask

  task automatic clr_ovr();
    pu_en = 0; dir_en = 0; out_en = 0; ie_en = 0;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    pad_in_i = '1;
    repeat (3) @(posedge clk);
    #1 rd_en_i = 1; addr_i = 2'd1;
    #1 chk("R1 dir read in reset", rdata_o, 0);
    addr_i = 2'd2;
    #1 chk("R1 out read in reset", rdata_o, 0);
    chk("R1 pad_oe", pad_oe_o, 0);
    chk("R1 pad_pu", pad_pu_o, 0);
    chk("R1 periph_in", periph_in_o, 0);
    @(posedge clk); #1 rst_ni = 1;
    step();

    // R2 writes to pin-state and reserved addresses change nothing
    wr_en_i = 1; wdata_i = 8'hA5; addr_i = 2'd0; step();
    addr_i = 2'd3; step();
    wr_en_i = 0; addr_i = 2'd1; step();
    chk("R2 dir after ignored writes", rdata_o, 0);

    // R5 pull-up gating by pud
    wr_en_i = 1; addr_i = 2'd2; wdata_i = 8'hFF; step();
    addr_i = 2'd1; wdata_i = 8'h0F; step();
    wr_en_i = 0;
    pud_i = 0; step();
    chk("R5 pull-up pud=0", pad_pu_o, 8'hF0);
    pud_i = 1; step();
    chk("R5 pull-up pud=1", pad_pu_o, 8'h00);
    // R6 override beats pud
    pu_en = 8'h81; pu_val = 8'h01; step();
    chk("R6 pull-up override", pad_pu_o, 8'h01);
    clr_ovr(); pud_i = 0;

    // R7/R8 sleep gating and synchronizer delay
    pad_in_i = 8'h3C; sleep_i = 1; step(); step();
    chk("R8 gated by sleep", periph_in_o, 0);
    sleep_i = 0; step(); step();
    chk("R8 after wake", periph_in_o, 8'h3C);
    ie_en = 8'h0F; ie_val = 8'h0C; sleep_i = 1; step(); step();
    chk("R7 ie override", pad_ie_o, 8'h0C);
    clr_ovr(); sleep_i = 0;

    // mixed random vectors with sparse overrides
    for (int k = 0; k < 3000; k++) begin
      sleep_i  = ($urandom % 4) == 0;
      pud_i    = ($urandom % 4) == 0;
      wr_en_i  = $urandom[0];
      rd_en_i  = ($urandom % 4) != 0;
      addr_i   = 2'($urandom);
      wdata_i  = 8'($urandom);
      pad_in_i = 8'($urandom);
      pu_en  = 8'($urandom & $urandom); pu_val  = 8'($urandom);
      dir_en = 8'($urandom & $urandom); dir_val = 8'($urandom);
      out_en = 8'($urandom & $urandom); out_val = 8'($urandom);
      ie_en  = 8'($urandom & $urandom); ie_val  = 8'($urandom);
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule